// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits on the memory side of a small single-port RAM. It executes each request as one indivisible step. A request has an opcode, a word address and two operands. Besides plain loads and stores, it carries out four synchronization primitives: test-and-set, fetch-and-add, swap and compare-and-swap. Each primitive reads the addressed word, decides whether and what to write back, and returns the word it found, together with a status bit.

Loads and stores take one cycle of occupancy, so they can be issued back to back. An atomic primitive holds the request interface for two cycles. In the first cycle the RAM is read. In the second cycle the write-back decision is made and the RAM is written, while the request ready signal is held low. Because of this, no other access can reach the RAM between the read and the write of a primitive. Software locks, counters and lock-free queues can be built directly on the responses.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Opcode 000 (load) returns the addressed word with `rsp_ok`=1, and `rsp_valid` is high in the cycle after acceptance.
- R2: Opcode 001 (store) writes `req_arg_a` to the addressed word. Its response comes in the cycle after acceptance with `rsp_data`=0 and `rsp_ok`=1. `req_ready` stays high.
- R3: Opcode 010 (test-and-set) returns the old word. It writes 1 only when the old word was 0, and `rsp_ok` is 1 exactly when the old word was 0.
- R4: Opcode 011 (fetch-and-add) returns the old word and writes the old word plus `req_arg_a`, wrapping modulo 2^DATA_W. `rsp_ok` is 1.
- R5: Opcode 100 (swap) writes `req_arg_a` and returns the previous word with `rsp_ok`=1.
- R6: Opcode 101 (compare-and-swap) writes `req_arg_b` only when the word equals `req_arg_a`, and then gives `rsp_ok`=1. Otherwise memory is unchanged and `rsp_ok`=0. In both cases `rsp_data` is the word that was read.
- R7: After an atomic opcode (010 to 101) is accepted, `req_ready` is low for exactly one cycle and the response comes two cycles after acceptance. A request accepted right afterwards sees the written value.
- R8: Opcodes 110 and 111 write nothing. They return the addressed word with `rsp_ok`=0 in the cycle after acceptance.
- R9: During and right after reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 3 | Opcode |
| req_addr | input | ADDR_W | Word address |
| req_arg_a | input | DATA_W | Store/swap data, addend, or compare value |
| req_arg_b | input | DATA_W | Replacement value for compare-and-swap |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_data | output | DATA_W | Word read (0 for a store) |
| rsp_ok | output | 1 | Status bit |

## Verification
The assertions run on every cycle and check the timing contract: the one-cycle stall after an atomic request, the response latency for both kinds of request, and how the status bit relates to the returned word for test-and-set and compare-and-swap. Only the bench's scenarios can show what ends up in memory. That covers the wrap of fetch-and-add, an unchanged word after a failed compare-and-swap, a reserved opcode that writes nothing, and a following access that observes the written value. The bench checks these against a reference memory model.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'b000,
        OP_STORE = 3'b001,
        OP_TAS   = 3'b010,
        OP_FADD  = 3'b011,
        OP_SWAP  = 3'b100,
        OP_CAS   = 3'b101,
        OP_RSV6  = 3'b110,
        OP_RSV7  = 3'b111
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } state_e;

    function automatic logic op_is_atomic(input op_e op);
        return (op == OP_TAS) || (op == OP_FADD) || (op == OP_SWAP) || (op == OP_CAS);
    endfunction

endpackage

// File: rtl/atomic_ram.sv
module atomic_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[addr] <= wdata;
            end else begin
                rdata <= mem_q[addr];
            end
        end
    end
endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
    import atomic_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] arg_a,
    input  logic [DATA_W-1:0] arg_b,
    output logic [DATA_W-1:0] new_word,
    output logic              wr_en,
    output logic              ok
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        new_word = old_word;
        wr_en    = 1'b0;
        ok       = 1'b1;
        unique case (op)
            OP_TAS: begin
                ok       = (old_word == '0);
                wr_en    = ok;
                new_word = ONE;
            end
            OP_FADD: begin
                wr_en    = 1'b1;
                new_word = old_word + arg_a;
            end
            OP_SWAP: begin
                wr_en    = 1'b1;
                new_word = arg_a;
            end
            OP_CAS: begin
                ok       = (old_word == arg_a);
                wr_en    = ok;
                new_word = arg_b;
            end
            default: begin
                ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_arg_a,
    input  logic [DATA_W-1:0] req_arg_b,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ok
);
    typedef struct packed {
        state_e            state;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] arg_a;
        logic [DATA_W-1:0] arg_b;
        logic              rsp_valid;
        logic              rsp_ok;
        logic              rsp_from_ram;
        logic [DATA_W-1:0] rsp_data;
    } regs_t;

    regs_t r_d, r_q;

    logic              accept;
    op_e               in_op;
    logic              ram_en;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] alu_new;
    logic              alu_we;
    logic              alu_ok;

    assign in_op     = op_e'(req_op);
    assign req_ready = (r_q.state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    atomic_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    atomic_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (r_q.op),
        .old_word (ram_rdata),
        .arg_a    (r_q.arg_a),
        .arg_b    (r_q.arg_b),
        .new_word (alu_new),
        .wr_en    (alu_we),
        .ok       (alu_ok)
    );

    // Single port: the execute cycle owns it, otherwise an accepted request does.
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = req_addr;
        ram_wdata = req_arg_a;
        if (r_q.state == ST_EXEC) begin
            ram_en    = alu_we;
            ram_we    = alu_we;
            ram_addr  = r_q.addr;
            ram_wdata = alu_new;
        end else if (accept) begin
            ram_en = 1'b1;
            ram_we = (in_op == OP_STORE);
        end
    end

    always_comb begin
        r_d              = r_q;
        r_d.rsp_valid    = 1'b0;
        r_d.rsp_from_ram = 1'b0;
        if (r_q.state == ST_EXEC) begin
            r_d.state     = ST_IDLE;
            r_d.rsp_valid = 1'b1;
            r_d.rsp_ok    = alu_ok;
            r_d.rsp_data  = ram_rdata;
        end else if (accept) begin
            if (op_is_atomic(in_op)) begin
                r_d.state = ST_EXEC;
                r_d.op    = in_op;
                r_d.addr  = req_addr;
                r_d.arg_a = req_arg_a;
                r_d.arg_b = req_arg_b;
            end else begin
                r_d.rsp_valid = 1'b1;
                r_d.rsp_data  = '0;
                unique case (in_op)
                    OP_STORE: begin
                        r_d.rsp_ok = 1'b1;
                    end
                    OP_LOAD: begin
                        r_d.rsp_ok       = 1'b1;
                        r_d.rsp_from_ram = 1'b1;
                    end
                    default: begin
                        r_d.rsp_ok       = 1'b0;
                        r_d.rsp_from_ram = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.op    <= OP_LOAD;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.rsp_valid;
    assign rsp_ok    = r_q.rsp_ok;
    assign rsp_data  = r_q.rsp_from_ram ? ram_rdata : r_q.rsp_data;
endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic [DATA_W-1:0] req_arg_a,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_ok
);
    logic acc, acc_atomic, acc_tas, acc_cas;
    assign acc        = req_valid && req_ready;
    assign acc_atomic = acc && (req_op >= 3'b010) && (req_op <= 3'b101);
    assign acc_tas    = acc && (req_op == 3'b010);
    assign acc_cas    = acc && (req_op == 3'b101);

    p_stall_after_atomic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_atomic |=> !req_ready);

    p_stall_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    p_atomic_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_atomic |=> !rsp_valid ##1 rsp_valid);

    p_single_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !acc_atomic) |=> rsp_valid);

    p_tas_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_tas, 2) |-> (rsp_valid && (rsp_ok == (rsp_data == '0))));

    p_cas_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_cas, 2) |-> (rsp_valid && (rsp_ok == ($past(req_arg_a, 2) == rsp_data))));
endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_arg_a (req_arg_a),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ok    (rsp_ok)
);

// File: tb/atomic_rmw_unit_test.sv
module atomic_rmw_unit_test;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = 3'b000;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_arg_a = '0;
    logic [DATA_W-1:0] req_arg_b = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] model [DEPTH];
    logic [DATA_W-1:0] q_data [$];
    logic              q_ok [$];
    string             q_tag [$];

    always #5 clk = ~clk;

    atomic_rmw_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_arg_a (req_arg_a),
        .req_arg_b (req_arg_b),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_ok    (rsp_ok)
    );

    task automatic check(input bit cond, input string tag, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: compute the expected response from the model, push it, then drive.
    task automatic issue(input logic [2:0] op, input int addr, input logic [DATA_W-1:0] a,
                         input logic [DATA_W-1:0] b, input string tag);
        logic [DATA_W-1:0] old, exp_d;
        logic              exp_ok;
        old    = model[addr];
        exp_d  = old;
        exp_ok = 1'b1;
        case (op)
            3'b000: ;
            3'b001: begin model[addr] = a; exp_d = '0; end
            3'b010: begin exp_ok = (old == '0); if (exp_ok) model[addr] = 1; end
            3'b011: model[addr] = old + a;
            3'b100: model[addr] = a;
            3'b101: begin exp_ok = (old == a); if (exp_ok) model[addr] = b; end
            default: exp_ok = 1'b0;
        endcase
        q_data.push_back(exp_d);
        q_ok.push_back(exp_ok);
        q_tag.push_back(tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = ADDR_W'(addr);
        req_arg_a = a;
        req_arg_b = b;
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (op >= 3'b010 && op <= 3'b101) begin
            @(negedge clk);
            check(!req_ready, "R7 ready low after atomic", {31'b0, req_ready}, '0);
        end
    endtask

    // Monitor: pop and compare every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R1 unexpected response", rsp_data, '0);
            end else begin
                logic [DATA_W-1:0] ed;
                logic              eo;
                string             t;
                ed = q_data.pop_front();
                eo = q_ok.pop_front();
                t  = q_tag.pop_front();
                check(rsp_data === ed, {t, " data"}, rsp_data, ed);
                check(rsp_ok === eo, {t, " ok"}, {31'b0, rsp_ok}, {31'b0, eo});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R9 rsp_valid in reset", {31'b0, rsp_valid}, '0);
        check(req_ready == 1'b1, "R9 ready in reset", {31'b0, req_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 rsp_valid after reset", {31'b0, rsp_valid}, '0);

        for (int i = 0; i < DEPTH; i++) issue(3'b001, i, DATA_W'(i * 3), '0, "R2 fill store");
        issue(3'b000, 10, '0, '0, "R1 load");
        issue(3'b001, 3, 32'h10, '0, "R2 store");
        issue(3'b000, 3, '0, '0, "R1 load after store");

        issue(3'b001, 5, '0, '0, "R2 clear lock");
        issue(3'b010, 5, '0, '0, "R3 tas free");
        issue(3'b010, 5, '0, '0, "R3 tas held");
        issue(3'b000, 5, '0, '0, "R3 lock word");
        issue(3'b010, 6, '0, '0, "R3 tas nonzero");

        issue(3'b001, 7, 32'hFFFF_FFFF, '0, "R2 store max");
        issue(3'b011, 7, 32'h2, '0, "R4 fadd wrap");
        issue(3'b000, 7, '0, '0, "R4 sum");
        issue(3'b011, 8, 32'h100, '0, "R4 fadd");

        issue(3'b100, 7, 32'hABCD, '0, "R5 swap");
        issue(3'b000, 7, '0, '0, "R5 swapped word");

        issue(3'b101, 7, 32'hABCD, 32'h55, "R6 cas hit");
        issue(3'b101, 7, 32'hABCD, 32'h66, "R6 cas miss");
        issue(3'b000, 7, '0, '0, "R6 word after miss");

        issue(3'b110, 7, 32'h9, 32'h9, "R8 reserved 6");
        issue(3'b111, 7, 32'h9, 32'h9, "R8 reserved 7");
        issue(3'b000, 7, '0, '0, "R8 word unchanged");

        for (int i = 0; i < 8; i++) begin
            issue(3'b011, 20, 32'h1, '0, "R7 fadd chain");
            issue(3'b000, 20, '0, '0, "R7 read after fadd");
        end
        for (int i = 0; i < 6; i++) issue(3'b000, 30 + i, '0, '0, "R1 back-to-back load");

        repeat (4) @(negedge clk);
        check(q_data.size() == 0, "R7 all responses seen", DATA_W'(q_data.size()), '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule